// File: doc/BRIEF.md
# Loop-Clock PLL Divider Chain

This block is the digital part of a loop-clock phase-locked loop. Two prescalers divide their input clocks, one on the reference side and one on the feedback side, each by 65 minus a 6-bit code. A tri-state up/down phase-frequency detector compares the rising edges of the two prescaled clocks. The analog charge pump, loop filter and oscillator are not part of the block. In their place, the block's own clock `clk` stands for the oscillator output. The post-scaler divides `clk` first by 2^P and then by 2(Q+1). An output multiplexer drives `clk_out` from the post-scaler or from the clock of a second PLL.

The codes are loaded through a four-entry byte register interface. Reads are combinational from `addr`. Some bits are fixed and always read as the same pattern. The reference and feedback inputs are slow clocks. They are synchronised into the `clk` domain and counted on their rising edges. A new divider code takes effect only at the next terminal count of the divider that uses it, so no output period is ever cut short.

The detector is a state machine with states PFD_IDLE, PFD_UP and PFD_DN. Its transitions are:
- IDLE to UP when only a reference edge arrives.
- IDLE to DN when only a feedback edge arrives.
- UP to IDLE when a feedback edge arrives.
- DN to IDLE when a reference edge arrives.
- In every other case the state holds. This includes both edges in one cycle while in IDLE.

The post-scaler is a state machine with states POST_LOW and POST_HIGH. It moves LOW to HIGH and HIGH to LOW at the end of each half period. It latches new P and Q codes only on the LOW to HIGH move.

Top module: `pll_divider_chain`

## Requirements
- R1: With N in bits 5:0 of register 0, `ref_div` has a period of (65 − N) rising edges of `ref_in`.
- R2: With M in bits 5:0 of register 1, `fb_div` has a period of (65 − M) rising edges of `fb_in`.
- R3: For an even prescaler ratio, the prescaler output stays high for half of the input edges in each period. For an odd ratio, it stays high for exactly one input period.
- R4: The post-scaler output `post_out` has a period of 2^P · 2(Q+1) cycles of `clk`, and it is high for half of them. P sits in bits 1:0 of register 2 and Q in bits 2:0 of register 3.
- R5: Reads return fixed bits, and writes to those bits are ignored:
  - register 0 reads {2'b11, N};
  - register 1 reads {2'b00, M};
  - register 2 reads {6'b111100, P};
  - register 3 reads {4'b0000, sel, Q}, where sel is bit 3.
- R6: A code written while a divider period is running does not change that period. The new ratio applies from the next period.
- R7: When sel (register 3 bit 3) is 1, `clk_out` follows `alt_clk`. When sel is 0, `clk_out` follows `post_out`.
- R8: A prescaled reference edge seen first raises `pfd_up`. A prescaled feedback edge seen first raises `pfd_dn`. The raised output holds through further edges of the same side. It clears, leaving both outputs low, on the next edge of the other side.
- R9: Reset does the following:
  - clears every counter;
  - holds `pfd_up` and `pfd_dn` low;
  - drives `ref_div`, `fb_div` and `post_out` low;
  - returns the registers to reads of 0xC0, 0x00, 0xF0 and 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator stand-in clock; clocks all logic |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Incoming loop clock, reference side |
| fb_in | input | 1 | Feedback clock |
| alt_clk | input | 1 | Clock from the other PLL |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| ref_div | output | 1 | Prescaled reference clock |
| fb_div | output | 1 | Prescaled feedback clock |
| pfd_up | output | 1 | Phase detector up output |
| pfd_dn | output | 1 | Phase detector down output |
| post_out | output | 1 | Post-scaler output |
| clk_out | output | 1 | Selected output clock |

## Verification
The hardest situation to reach is a detector state that has been held by a repeated same-side edge. The free-running input clocks never produce it in a controlled way. To get there, the bench stops both generators and sets both prescalers to a ratio of 2. It then pulses one input at a time until the matching prescaled output is seen to rise. This places each prescaled edge on a known cycle. The bench then checks that the detector enters, holds and leaves its states. The mid-period code change is reached in a similar way: the bench waits for an observed output rise and writes the new code on the cycle that follows.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
    localparam int DATA_W = 8;
    localparam int CODE_W = 6;
    localparam int P_W    = 2;
    localparam int Q_W    = 3;

    localparam logic [DATA_W-CODE_W-1:0] N_FIXED = '1;
    localparam logic [DATA_W-CODE_W-1:0] M_FIXED = '0;
    localparam logic [DATA_W-P_W-1:0]    P_FIXED = 6'b111100;

    typedef enum logic [1:0] {
        REG_N    = 2'd0,
        REG_M    = 2'd1,
        REG_P    = 2'd2,
        REG_CTRL = 2'd3
    } reg_addr_t;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2
    } pfd_state_t;

    typedef enum logic {
        POST_LOW  = 1'b0,
        POST_HIGH = 1'b1
    } post_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] n_code;
        logic [CODE_W-1:0] m_code;
        logic [P_W-1:0]    p_code;
        logic [Q_W-1:0]    q_code;
        logic              sel_alt;
    } pll_cfg_t;
endpackage

// File: rtl/pll_regs.sv
module pll_regs
    import pll_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output pll_cfg_t          cfg,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CTRL_PAD = DATA_W - Q_W - 1;

    reg_addr_t sel_addr;
    assign sel_addr = reg_addr_t'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            unique case (sel_addr)
                REG_N:    cfg.n_code <= wr_data[CODE_W-1:0];
                REG_M:    cfg.m_code <= wr_data[CODE_W-1:0];
                REG_P:    cfg.p_code <= wr_data[P_W-1:0];
                REG_CTRL: begin
                    cfg.q_code  <= wr_data[Q_W-1:0];
                    cfg.sel_alt <= wr_data[Q_W];
                end
            endcase
        end
    end

    always_comb begin
        unique case (sel_addr)
            REG_N:    rd_data = {N_FIXED, cfg.n_code};
            REG_M:    rd_data = {M_FIXED, cfg.m_code};
            REG_P:    rd_data = {P_FIXED, cfg.p_code};
            REG_CTRL: rd_data = {{CTRL_PAD{1'b0}}, cfg.sel_alt, cfg.q_code};
        endcase
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(cfg)); // R5
endmodule

// File: rtl/presc_div.sv
module presc_div #(
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_in,
    input  logic [CODE_W-1:0] code,
    output logic              div_out,
    output logic              div_rise
);
    localparam int CNT_W = CODE_W + 1;
    localparam logic [CNT_W-1:0] LIM_MAX = CNT_W'(1 << CODE_W);

    logic [SYNC_STAGES:0] sync_q;
    logic                 ev;
    logic [CNT_W-1:0]     cnt_q, lim_q;
    logic [CNT_W-1:0]     cnt_n, lim_n, rat_n, new_lim;
    logic                 wrap, out_n, out_q, rise_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-1:0], clk_in};
    end
    assign ev = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    always_comb begin
        new_lim = LIM_MAX - {1'b0, code};
        wrap    = (cnt_q == lim_q);
        cnt_n   = wrap ? '0 : cnt_q + 1'b1;
        lim_n   = wrap ? new_lim : lim_q;
        rat_n   = lim_n + 1'b1;
        if (lim_n[0]) out_n = (cnt_n < (rat_n >> 1));
        else          out_n = (cnt_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lim_q  <= '0;
            out_q  <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            if (ev) begin
                cnt_q  <= cnt_n;
                lim_q  <= lim_n;
                out_q  <= out_n;
                rise_q <= out_n & ~out_q;
            end
        end
    end

    assign div_out  = out_q;
    assign div_rise = rise_q;

    AST_PRESC_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt_q <= lim_q); // R1
    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (rst) !ev |=> $stable(div_out)); // R3
    AST_PRESC_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (rst) div_rise |-> (cnt_q == '0)); // R6
endmodule

// File: rtl/post_div.sv
module post_div
    import pll_div_pkg::*;
#(
    parameter int PW = 2,
    parameter int QW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] p_code,
    input  logic [QW-1:0] q_code,
    output logic          post_out
);
    localparam int PRE_W = (1 << PW) - 1;

    post_state_t      state_q, state_n;
    logic [PRE_W-1:0] pre_cnt, pre_lim;
    logic [QW-1:0]    half_cnt, q_lat;
    logic [PW-1:0]    p_lat;
    logic             tick, half_end, reload;

    always_comb begin
        pre_lim  = PRE_W'((1 << p_lat) - 1);
        tick     = (pre_cnt == pre_lim);
        half_end = tick && (half_cnt == q_lat);
        reload   = half_end && (state_q == POST_LOW);
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            POST_LOW:  if (half_end) state_n = POST_HIGH;
            POST_HIGH: if (half_end) state_n = POST_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= POST_LOW;
        else     state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt  <= '0;
            half_cnt <= '0;
            p_lat    <= '0;
            q_lat    <= '0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
            if (half_end)  half_cnt <= '0;
            else if (tick) half_cnt <= half_cnt + 1'b1;
            if (reload) begin
                p_lat <= p_code;
                q_lat <= q_code;
            end
        end
    end

    assign post_out = (state_q == POST_HIGH);

    AST_POST_CODE_HELD: assert property (@(posedge clk) disable iff (rst) !reload |=> ($stable(p_lat) && $stable(q_lat))); // R6
    AST_POST_TOGGLE_AT_HALF: assert property (@(posedge clk) disable iff (rst) !half_end |=> $stable(post_out)); // R4
endmodule

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
    import pll_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic up,
    output logic dn
);
    pfd_state_t state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            PFD_IDLE: begin
                if (ref_rise && !fb_rise)      state_n = PFD_UP;
                else if (fb_rise && !ref_rise) state_n = PFD_DN;
            end
            PFD_UP:   if (fb_rise)  state_n = PFD_IDLE;
            PFD_DN:   if (ref_rise) state_n = PFD_IDLE;
            default:  state_n = PFD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PFD_IDLE;
        else     state_q <= state_n;
    end

    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state_q)
            PFD_UP:  up = 1'b1;
            PFD_DN:  dn = 1'b1;
            default: ;
        endcase
    end

    AST_PFD_UP_CLEARS: assert property (@(posedge clk) disable iff (rst) (up && fb_rise) |=> (!up && !dn)); // R8
    AST_PFD_DN_CLEARS: assert property (@(posedge clk) disable iff (rst) (dn && ref_rise) |=> (!up && !dn)); // R8
    AST_PFD_UP_HOLDS: assert property (@(posedge clk) disable iff (rst) (up && !fb_rise) |=> up); // R8
endmodule

// File: rtl/pll_divider_chain.sv
module pll_divider_chain
    import pll_div_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              fb_in,
    input  logic              alt_clk,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              ref_div,
    output logic              fb_div,
    output logic              pfd_up,
    output logic              pfd_dn,
    output logic              post_out,
    output logic              clk_out
);
    localparam int NUM_PRESC = 2;

    pll_cfg_t           cfg;
    logic [NUM_PRESC-1:0] raw_in, div_vec, rise_vec;
    logic [CODE_W-1:0]    codes [NUM_PRESC];

    pll_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    assign raw_in   = {fb_in, ref_in};
    assign codes[0] = cfg.n_code;
    assign codes[1] = cfg.m_code;

    for (genvar g = 0; g < NUM_PRESC; g++) begin : g_presc
        presc_div #(
            .CODE_W      (CODE_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_presc (
            .clk      (clk),
            .rst      (rst),
            .clk_in   (raw_in[g]),
            .code     (codes[g]),
            .div_out  (div_vec[g]),
            .div_rise (rise_vec[g])
        );
    end

    assign ref_div = div_vec[0];
    assign fb_div  = div_vec[1];

    pfd_ctrl u_pfd (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (rise_vec[0]),
        .fb_rise  (rise_vec[1]),
        .up       (pfd_up),
        .dn       (pfd_dn)
    );

    post_div #(
        .PW (P_W),
        .QW (Q_W)
    ) u_post (
        .clk      (clk),
        .rst      (rst),
        .p_code   (cfg.p_code),
        .q_code   (cfg.q_code),
        .post_out (post_out)
    );

    assign clk_out = cfg.sel_alt ? alt_clk : post_out;
endmodule

// File: tb/pll_divider_chain_bench.sv
`timescale 1ns/1ps
module pll_divider_chain_bench;
    logic clk = 1'b0, rst = 1'b1;
    logic ref_in = 1'b0, fb_in = 1'b0, alt_clk = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic ref_div, fb_div, pfd_up, pfd_dn, post_out, clk_out;
    logic ref_run = 1'b0, fb_run = 1'b0;
    int checks = 0, fails = 0;
    bit done = 0;

    pll_divider_chain u_pll_divider_chain (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .alt_clk(alt_clk),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .ref_div(ref_div), .fb_div(fb_div), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
        .post_out(post_out), .clk_out(clk_out)
    );

    always #2.5 clk = ~clk;
    always #10 if (ref_run) ref_in = ~ref_in;
    always #15 if (fb_run) fb_in = ~fb_in;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic sig(int s);
        case (s)
            0: return ref_div;
            1: return fb_div;
            2: return post_out;
            default: return clk_out;
        endcase
    endfunction

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [1:0] a, int exp);
        addr = a;
        #1;
        check(tag, int'(rd_data), exp);
        @(negedge clk);
    endtask

    task automatic wait_rise(int s);
        logic prev, cur;
        prev = sig(s);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            cur = sig(s);
            if (cur && !prev) return;
            prev = cur;
        end
    endtask

    task automatic from_rise(int s, output int per, output int hi);
        logic prev, cur;
        per = 0; hi = 1; prev = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            per++;
            cur = sig(s);
            if (cur && !prev) return;
            if (cur) hi++;
            prev = cur;
        end
    endtask

    task automatic measure(string tag, int s, int exp_per, int exp_hi);
        int per, hi;
        wait_rise(s);
        wait_rise(s);
        from_rise(s, per, hi);
        check({tag, " period"}, per, exp_per);
        check({tag, " high"}, hi, exp_hi);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 up in reset", int'(pfd_up), 0);
        check("R9 dn in reset", int'(pfd_dn), 0);
        check("R9 post_out in reset", int'(post_out), 0);
        check("R9 ref_div in reset", int'(ref_div), 0);
        check("R9 fb_div in reset", int'(fb_div), 0);
        rst = 1'b0;
        @(negedge clk);
        rd_check("R9 reg0 reset", 2'd0, 8'hC0);
        rd_check("R9 reg1 reset", 2'd1, 8'h00);
        rd_check("R9 reg2 reset", 2'd2, 8'hF0);
        rd_check("R9 reg3 reset", 2'd3, 8'h00);
    endtask

    task automatic test_regs();
        wr(2'd0, 8'h21); rd_check("R5 N read", 2'd0, 8'hE1);
        wr(2'd0, 8'h3F); rd_check("R5 N fixed", 2'd0, 8'hFF);
        wr(2'd1, 8'hFD); rd_check("R5 M read", 2'd1, 8'h3D);
        wr(2'd2, 8'hFF); rd_check("R5 P read", 2'd2, 8'hF3);
        wr(2'd2, 8'h01); rd_check("R5 P low", 2'd2, 8'hF1);
        wr(2'd3, 8'hF5); rd_check("R5 ctrl read", 2'd3, 8'h05);
        wr(2'd3, 8'h00);
    endtask

    task automatic test_ref();
        ref_run = 1'b1;
        wr(2'd0, 8'h21); measure("R1 R3 ratio32", 0, 128, 64);
        wr(2'd0, 8'h3E); measure("R3 odd ratio3", 0, 12, 4);
        wr(2'd0, 8'h00); measure("R1 R3 ratio65", 0, 260, 4);
        wr(2'd0, 8'h3F); measure("R1 ratio2", 0, 8, 4);
    endtask

    task automatic test_fb();
        fb_run = 1'b1;
        wr(2'd1, 8'h3D); measure("R2 ratio4", 1, 24, 12);
        wr(2'd1, 8'h3C); measure("R2 R3 ratio5", 1, 30, 6);
    endtask

    task automatic test_post();
        wr(2'd2, 8'h01); wr(2'd3, 8'h00); measure("R4 P1Q0", 2, 4, 2);
        wr(2'd2, 8'h03); wr(2'd3, 8'h07); measure("R4 P3Q7", 2, 128, 64);
        wr(2'd2, 8'h00); wr(2'd3, 8'h00); measure("R4 P0Q0", 2, 2, 1);
        wr(2'd2, 8'h02); wr(2'd3, 8'h02); measure("R4 R7 clk_out P2Q2", 3, 24, 12);
    endtask

    task automatic test_change();
        int per, hi;
        wr(2'd0, 8'h21); measure("R6 ref settle", 0, 128, 64);
        wait_rise(0);
        wr(2'd0, 8'h3E);
        from_rise(0, per, hi);
        check("R6 ref old period kept", per + 1, 128);
        from_rise(0, per, hi);
        check("R6 ref new period", per, 12);
        wr(2'd2, 8'h01); wr(2'd3, 8'h00); measure("R6 post settle", 2, 4, 2);
        wait_rise(2);
        wr(2'd2, 8'h03);
        from_rise(2, per, hi);
        check("R6 post old period kept", per + 1, 4);
        from_rise(2, per, hi);
        check("R6 post new period", per, 16);
    endtask

    task automatic test_select();
        int mism = 0;
        wr(2'd3, 8'h08);
        alt_clk = 1'b1; @(negedge clk);
        check("R7 alt high", int'(clk_out), 1);
        alt_clk = 1'b0; @(negedge clk);
        check("R7 alt low", int'(clk_out), 0);
        wr(2'd3, 8'h00);
        alt_clk = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (clk_out != post_out) mism++;
        end
        check("R7 post selected", mism, 0);
    endtask

    task automatic pulse_until(int side, output bit rose);
        logic prev;
        rose = 0;
        prev = sig(side);
        for (int k = 0; k < 10 && !rose; k++) begin
            for (int j = 0; j < 8; j++) begin
                if (side == 0) ref_in = (j < 4); else fb_in = (j < 4);
                @(negedge clk);
                if (sig(side) && !prev) begin rose = 1; break; end
                prev = sig(side);
            end
        end
    endtask

    task automatic test_pfd();
        bit r;
        ref_run = 1'b0; fb_run = 1'b0;
        #1; ref_in = 1'b0; fb_in = 1'b0;
        @(negedge clk);
        do_reset();
        wr(2'd0, 8'h3F); wr(2'd1, 8'h3F);
        repeat (4) @(negedge clk);
        pulse_until(0, r); check("R8 ref edge seen", int'(r), 1);
        @(negedge clk);
        check("R8 up after ref", int'(pfd_up), 1);
        check("R8 dn after ref", int'(pfd_dn), 0);
        pulse_until(0, r); @(negedge clk);
        check("R8 up held on second ref", int'(pfd_up), 1);
        pulse_until(1, r); @(negedge clk);
        check("R8 up cleared by fb", int'(pfd_up), 0);
        check("R8 dn low after clear", int'(pfd_dn), 0);
        pulse_until(1, r); @(negedge clk);
        check("R8 dn after fb", int'(pfd_dn), 1);
        check("R8 up low with dn", int'(pfd_up), 0);
        pulse_until(0, r); @(negedge clk);
        check("R8 dn cleared by ref", int'(pfd_dn), 0);
        pulse_until(0, r); @(negedge clk);
        check("R8 up again", int'(pfd_up), 1);
        rst = 1'b1;
        @(negedge clk);
        check("R9 up low on reset", int'(pfd_up), 0);
        check("R9 ref_div low on reset", int'(ref_div), 0);
        rst = 1'b0;
        @(negedge clk);
        rd_check("R9 reg0 after reset", 2'd0, 8'hC0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_regs();
        test_ref();
        test_fb();
        test_post();
        test_change();
        test_select();
        test_pfd();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule